// File: doc/BRIEF.md
# Key Matrix Interrupt Controller

This block watches a small group of active-low key pins and raises one interrupt request toward the processor when a key goes down. Each pin has its own enable bit. Pins that are switched off are ignored, and pins that are switched on also turn on that pin's pull-up. The enabled pins are merged into a single "some key is down" signal. That signal is synchronized to the bus clock, and its falling edge (keys going from all released to at least one pressed) latches a request flag.

Two modes control how the flag clears. In edge mode, a single acknowledge clears the flag whatever the pins are doing. In level mode, the flag clears only after an acknowledge has been seen and every enabled pin has returned high. An acknowledge can come from the processor's interrupt-vector fetch strobe or from software writing a one to a write-only bit. A mask bit keeps the flag from reaching the interrupt output while still letting it set, so software can poll. Software reaches the block through two byte-wide registers on a simple address/strobe bus.

Top module: `kbd_irq_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, `pull_en_o` is 0 and `irq_o` is 0.
- R2: The enable register is at address 1. Bits [3:0] are the per-pin enables for `key_n_i[3:0]`. Bits [7:4] read 0. `pull_en_o` equals the enable bits.
- R3: The control register is at address 0. Bit 0 selects level mode (1) or edge mode (0). Bit 1 is the mask. Bit 2 is the write-only acknowledge and always reads 0. Bit 3 is the request flag, which is read-only: writes to it have no effect. Bits [7:4] read 0.
- R4: The flag is set when the merged enabled-key signal goes from all released to at least one pressed. It is set on the third rising clock edge after the pin change, because the signal passes a two-stage synchronizer and a previous-value compare. Disabled pins are ignored. A second key that goes down while another enabled key is still held causes no new edge.
- R5: In edge mode, writing 1 to control bit 2 clears the flag on that write's clock edge, even while a key is held low. A key that stays held does not set the flag again.
- R6: A one-cycle pulse on `vec_ack_i` acknowledges exactly as the software acknowledge does.
- R7: In level mode, the flag stays set while any enabled pin is low, even after an acknowledge. It clears once an acknowledge has been seen and all enabled pins are high. Releasing the keys with no acknowledge leaves the flag set.
- R8: A falling edge after an acknowledge sets the flag again. If a set and an acknowledge fall in the same cycle, the set wins.
- R9: `irq_o` is the flag gated by the inverse of the mask, registered, so it follows the flag one clock later. When the mask is 1, the flag still sets but `irq_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Register address (0 control, 1 enable) |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Registered read data for the address presented on the previous cycle |
| key_n_i | input | NUM_KEYS | Raw active-low key pins |
| vec_ack_i | input | 1 | Acknowledge pulse from the interrupt-vector fetch |
| pull_en_o | output | NUM_KEYS | Per-pin pull-up enable |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench uses the default parameters: four keys, byte-wide data, a one-bit address and a two-stage synchronizer. With four keys, one pin can be left disabled while two enabled pins overlap, so the test reaches the disabled-pin case and the merged-signal case where no new edge appears. The two-stage depth fixes the set latency at three edges, so the bench can drive an acknowledge into exactly the cycle in which the set lands. It also checks the exact edge on which the flag becomes visible, along with the one-cycle lag of the interrupt output.

// File: rtl/kbd_pkg.sv
`timescale 1ns/1ps
package kbd_pkg;
  // control register bit positions; the bench and software decode these
  localparam int unsigned CTRL_MODE = 0;
  localparam int unsigned CTRL_MASK = 1;
  localparam int unsigned CTRL_ACK  = 2;
  localparam int unsigned CTRL_FLAG = 3;

  typedef struct packed {
    logic mask;
    logic level_mode;
  } kbd_ctrl_t;
endpackage

// File: rtl/kbd_sync.sv
`timescale 1ns/1ps
module kbd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/kbd_event.sv
`timescale 1ns/1ps
module kbd_event (
  input  logic clk,
  input  logic rst,
  input  logic key_low_i,    // synchronized: some enabled key is down
  input  logic level_mode_i,
  input  logic ack_i,
  output logic flag_o
);
  logic prev_q;
  logic flag_q;
  logic ack_seen_q;
  logic set_evt;

  assign set_evt = key_low_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q     <= 1'b0;
      flag_q     <= 1'b0;
      ack_seen_q <= 1'b0;
    end else begin
      prev_q <= key_low_i;
      if (set_evt) begin
        // a new press always wins over an acknowledge in the same cycle
        flag_q     <= 1'b1;
        ack_seen_q <= 1'b0;
      end else if (flag_q) begin
        if (!level_mode_i) begin
          ack_seen_q <= 1'b0;
          if (ack_i) flag_q <= 1'b0;
        end else if ((ack_i || ack_seen_q) && !key_low_i) begin
          flag_q     <= 1'b0;
          ack_seen_q <= 1'b0;
        end else if (ack_i) begin
          ack_seen_q <= 1'b1;
        end
      end else begin
        ack_seen_q <= 1'b0;
      end
    end
  end

  assign flag_o = flag_q;

  a_r4_rise_needs_key: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(key_low_i));

  a_r5_edge_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (!level_mode_i && flag_q && ack_i && !(key_low_i && !prev_q)) |=> !flag_q);

  a_r7_level_hold: assert property (@(posedge clk) disable iff (rst)
    (level_mode_i && flag_q && key_low_i) |=> flag_q);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (key_low_i && !prev_q) |=> flag_q);
endmodule

// File: rtl/kbd_regs.sv
`timescale 1ns/1ps
module kbd_regs
  import kbd_pkg::*;
#(
  parameter int unsigned NUM_KEYS  = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 1,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned EN_ADDR   = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                flag_i,
  output logic [NUM_KEYS-1:0] en_o,
  output kbd_ctrl_t           ctrl_o,
  output logic                sw_ack_o,
  output logic [DATA_W-1:0]   rd_data_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_ADDR);

  logic [NUM_KEYS-1:0] en_q;
  kbd_ctrl_t           ctrl_q;
  logic [DATA_W-1:0]   rd_q;
  logic [DATA_W-1:0]   rd_mux;
  logic                wr_ctrl;
  logic                wr_en_reg;
  logic                unused_wr_hi;

  assign wr_ctrl      = wr_en_i && (addr_i == CTRL_A);
  assign wr_en_reg    = wr_en_i && (addr_i == EN_A);
  assign unused_wr_hi = ^wr_data_i[DATA_W-1:CTRL_ACK+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_en_reg) en_q <= wr_data_i[NUM_KEYS-1:0];
      if (wr_ctrl) begin
        ctrl_q.mask       <= wr_data_i[CTRL_MASK];
        ctrl_q.level_mode <= wr_data_i[CTRL_MODE];
      end
    end
  end

  // acknowledge is a strobe only; it never lands in storage
  assign sw_ack_o = wr_ctrl && wr_data_i[CTRL_ACK];

  always_comb begin
    rd_mux = '0;
    if (addr_i == CTRL_A) begin
      rd_mux[CTRL_FLAG] = flag_i;
      rd_mux[CTRL_MASK] = ctrl_q.mask;
      rd_mux[CTRL_MODE] = ctrl_q.level_mode;
    end else if (addr_i == EN_A) begin
      rd_mux[NUM_KEYS-1:0] = en_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_mux;
  end

  assign en_o      = en_q;
  assign ctrl_o    = ctrl_q;
  assign rd_data_o = rd_q;

  a_r2_en_write: assert property (@(posedge clk) disable iff (rst)
    wr_en_reg |=> (en_q == $past(wr_data_i[NUM_KEYS-1:0])));

  a_r3_mode_write: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (ctrl_q.level_mode == $past(wr_data_i[CTRL_MODE])));
endmodule

// File: rtl/kbd_irq_ctrl.sv
`timescale 1ns/1ps
module kbd_irq_ctrl
  import kbd_pkg::*;
#(
  parameter int unsigned NUM_KEYS    = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CTRL_ADDR   = 0,
  parameter int unsigned EN_ADDR     = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [NUM_KEYS-1:0] key_n_i,
  input  logic                vec_ack_i,
  output logic [NUM_KEYS-1:0] pull_en_o,
  output logic                irq_o
);
  logic [NUM_KEYS-1:0] en;
  kbd_ctrl_t           ctrl;
  logic                sw_ack;
  logic                flag;
  logic                any_low_raw;
  logic                any_low_sync;
  logic                irq_q;

  kbd_regs #(
    .NUM_KEYS (NUM_KEYS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .EN_ADDR  (EN_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .flag_i   (flag),
    .en_o     (en),
    .ctrl_o   (ctrl),
    .sw_ack_o (sw_ack),
    .rd_data_o(rd_data_o)
  );

  // merged key: high when any enabled pin is pulled low
  assign any_low_raw = |(~key_n_i & en);

  kbd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i(any_low_raw),
    .q_o(any_low_sync)
  );

  kbd_event u_event (
    .clk         (clk),
    .rst         (rst),
    .key_low_i   (any_low_sync),
    .level_mode_i(ctrl.level_mode),
    .ack_i       (sw_ack | vec_ack_i),
    .flag_o      (flag)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= flag & ~ctrl.mask;
  end

  assign irq_o     = irq_q;
  assign pull_en_o = en;

  a_r9_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl.mask) |-> !irq_o);

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(flag));
endmodule

// File: tb/test_kbd_irq_ctrl.sv
`timescale 1ns/1ps
module test_kbd_irq_ctrl;
  localparam logic CA = 1'b0;  // control register address
  localparam logic EA = 1'b1;  // enable register address

  typedef struct {
    logic [7:0] rd;
    logic       irq;
    logic [3:0] pull;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       addr = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [3:0] key_n = 4'hF;
  logic       vec_ack = 1'b0;
  logic [3:0] pull;
  logic       irq;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  exp_t sb_q[$];
  event sample_ev;

  always #4 clk = ~clk;  // 125 MHz

  kbd_irq_ctrl i_kbd_irq_ctrl (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (addr),
    .wr_en_i  (wr_en),
    .wr_data_i(wdata),
    .rd_data_o(rdata),
    .key_n_i  (key_n),
    .vec_ack_i(vec_ack),
    .pull_en_o(pull),
    .irq_o    (irq)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic ack_pulse();
    vec_ack = 1'b1;
    step(1);
    vec_ack = 1'b0;
  endtask

  // driver: present address, push expectation, let monitor compare after one edge
  task automatic chk(logic a, logic [7:0] erd, logic eirq, logic [3:0] epull, string tag);
    exp_t it;
    it.rd = erd; it.irq = eirq; it.pull = epull; it.tag = tag;
    addr = a;
    sb_q.push_back(it);
    step(1);
    -> sample_ev;
    #1;
  endtask

  // monitor
  initial begin
    forever begin
      exp_t it;
      @(sample_ev);
      it = sb_q.pop_front();
      checks++;
      if (rdata !== it.rd || irq !== it.irq || pull !== it.pull) begin
        fails++;
        $display("FAIL %s: rd=%02h irq=%0b pull=%h expected rd=%02h irq=%0b pull=%h",
                 it.tag, rdata, irq, pull, it.rd, it.irq, it.pull);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(5);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk(CA, 8'h00, 1'b0, 4'h0, "R1 control after reset");
    chk(EA, 8'h00, 1'b0, 4'h0, "R1 enable after reset");
    // R2 enable register and pull-ups
    wr(EA, 8'hFF);
    chk(EA, 8'h0F, 1'b0, 4'hF, "R2 upper enable bits read zero");
    wr(EA, 8'h05);
    chk(EA, 8'h05, 1'b0, 4'h5, "R2 pull follows enables");
    // R4 disabled pin ignored
    key_n[1] = 1'b0;
    step(4);
    chk(CA, 8'h00, 1'b0, 4'h5, "R4 disabled pin ignored");
    key_n[1] = 1'b1;
    step(4);
    // R3 flag read-only, ack reads zero, upper bits zero
    wr(CA, 8'hFF);
    chk(CA, 8'h03, 1'b0, 4'h5, "R3 control layout");
    wr(CA, 8'h00);
    // R4 exact latency, R9 one-cycle irq lag
    key_n[0] = 1'b0;
    step(2);
    chk(CA, 8'h00, 1'b0, 4'h5, "R4 not set before third edge");
    chk(CA, 8'h08, 1'b1, 4'h5, "R4 set on third edge, R9 irq next");
    // R5 software ack clears while held
    wr(CA, 8'h04);
    chk(CA, 8'h00, 1'b0, 4'h5, "R5 ack clears while key low");
    step(4);
    chk(CA, 8'h00, 1'b0, 4'h5, "R5 held key does not retrigger");
    // R4 merged signal: second key while first held
    key_n[2] = 1'b0;
    step(4);
    chk(CA, 8'h00, 1'b0, 4'h5, "R4 overlapping key gives no edge");
    key_n = 4'hF;
    step(4);
    // R8 new edge after ack
    key_n[2] = 1'b0;
    step(4);
    chk(CA, 8'h08, 1'b1, 4'h5, "R8 new press after ack sets");
    wr(CA, 8'h04);
    key_n[2] = 1'b1;
    step(4);
    // R6 vector-fetch ack
    key_n[0] = 1'b0;
    step(4);
    chk(CA, 8'h08, 1'b1, 4'h5, "R6 flag before vector ack");
    ack_pulse();
    chk(CA, 8'h00, 1'b0, 4'h5, "R6 vector ack clears");
    key_n[0] = 1'b1;
    step(4);
    // R8 set and ack in the same cycle
    key_n[0] = 1'b0;
    step(2);
    ack_pulse();
    chk(CA, 8'h08, 1'b1, 4'h5, "R8 set wins over same-cycle ack");
    wr(CA, 8'h04);
    key_n[0] = 1'b1;
    step(4);
    // R7 level mode
    wr(CA, 8'h01);
    key_n[0] = 1'b0;
    step(4);
    chk(CA, 8'h09, 1'b1, 4'h5, "R7 level mode set");
    wr(CA, 8'h05);
    step(3);
    chk(CA, 8'h09, 1'b1, 4'h5, "R7 held low after ack keeps flag");
    key_n[0] = 1'b1;
    step(4);
    chk(CA, 8'h01, 1'b0, 4'h5, "R7 clears after ack and release");
    key_n[2] = 1'b0;
    step(4);
    chk(CA, 8'h09, 1'b1, 4'h5, "R7 second press sets");
    key_n[2] = 1'b1;
    step(4);
    chk(CA, 8'h09, 1'b1, 4'h5, "R7 release without ack keeps flag");
    ack_pulse();
    chk(CA, 8'h01, 1'b0, 4'h5, "R7 vector ack with pins high clears");
    // R9 mask
    wr(CA, 8'h02);
    key_n[0] = 1'b0;
    step(4);
    chk(CA, 8'h0A, 1'b0, 4'h5, "R9 masked flag sets, no irq");
    wr(CA, 8'h00);
    step(1);
    chk(CA, 8'h08, 1'b1, 4'h5, "R9 unmask raises irq");
    wr(CA, 8'h04);
    key_n[0] = 1'b1;
    step(4);
    chk(CA, 8'h00, 1'b0, 4'h5, "R9 irq drops after ack");

    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule